// File: doc/BRIEF.md
# Segmented DAC Digital Front End

This block sits between the sample input of a 10-bit segmented current-steering converter and its array of switched current cells. Each clock it accepts one new input word. The word splits into an upper 5-bit field and a lower 5-bit field. The upper field drives 31 equally weighted cells through a pipelined thermometer encoder. The lower field drives 5 binary-weighted cells.

The lower field passes through a register delay whose depth equals the encoder latency, so both fields reach the cell drivers in the same cycle. Every cell, unary or binary, then goes through an identical synchronising flop that produces a true/complement pair: one rail for each side of the differential output. The encoder latency is a parameter, and the binary delay follows it automatically.

A synchronous reset parks the whole pipeline at a defined mid-scale word. That word is 16 unary cells on and binary field 10000, which is code 528. The output therefore rests at this word until the first post-reset sample has crossed the pipeline.

Top module: `segdac_frontend`

## Requirements
- R1: With ENC_LAT=2, the value (number of unary cells on) × 32 + (binary field) equals the input code applied ENC_LAT+1 clock edges earlier, for every one of the 1024 codes.
- R2: The unary on-lines form a thermometer. For upper field value m, lines 0 through m−1 are on and lines m through 30 are off.
- R3: Binary line i (0..4) carries bit i of the lower input field, and its weight is 2^i.
- R4: Both segments change in the same cycle. A step from code 0 to 1023 moves unary and binary outputs together, exactly ENC_LAT+1 edges after the step is sampled, and not one edge earlier.
- R5: In every registered cycle, each cell's complement rail is the inverse of its true rail, for unary and binary cells alike.
- R6: While rst is high at a clock edge, the outputs go to the mid word on the next cycle, whatever the input. The mid word is unary lines 0..15 on, lines 16..30 off, and binary 10000.
- R7: After reset is released, the outputs stay at the mid word until the first sample taken after release has crossed the full latency.
- R8: A different sample can be applied on every clock with no gaps, and consecutive outputs follow the input order one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | MSB_W+LSB_W (10) | Input sample, upper field unary and lower field binary |
| unary_p | output | 2^MSB_W−1 (31) | True rail of unary cell drives |
| unary_n | output | 2^MSB_W−1 (31) | Complement rail of unary cell drives |
| bin_p | output | LSB_W (5) | True rail of binary cell drives |
| bin_n | output | LSB_W (5) | Complement rail of binary cell drives |

## Verification
On every cycle, the assertions check four things: rail complementarity, thermometer shape of the encoder output, the mid word on the first cycle after reset, and latency alignment of both segments whenever the input has been steady for the full pipeline depth. The ordering of back-to-back changing samples, and the absence of an early or late transition in either segment, can only be shown by the bench. It does this by sweeping all 1024 codes without gaps, stepping between extremes, and resetting mid-stream against an arithmetic model of the delay.

// File: rtl/segdac_pkg.sv
package segdac_pkg;

  // drive state of one switched cell: both rails held in one register
  typedef struct packed {
    logic drv_p;
    logic drv_n;
  } cell_drv_t;

  // mid-scale value of a field of the given width (top bit set)
  function automatic int unsigned field_mid(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

endpackage

// File: rtl/segdac_pipe.sv
module segdac_pipe #(
  parameter int W     = 5,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] rst_val,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= rst_val;
        else     stg[k] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[k] <= rst_val;
        else     stg[k] <= stg[k-1];
      end
    end
  end

  assign q = stg[DEPTH-1];

endmodule

// File: rtl/segdac_therm_enc.sv
module segdac_therm_enc #(
  parameter int CODE_W = 5,
  parameter int SUB_W  = 3,
  parameter int LAT    = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CODE_W-1:0]         code_i,
  output logic [(1<<CODE_W)-2:0]    therm_o
);

  localparam int LINES = (1 << CODE_W) - 1;
  localparam int HI_W  = CODE_W - SUB_W;
  localparam int GRP   = 1 << HI_W;
  localparam int SUBL  = 1 << SUB_W;
  localparam int MID   = int'(segdac_pkg::field_mid(CODE_W));
  localparam int TAIL  = (LAT > 1) ? LAT - 1 : 1;

  // decomposition: group selects (above / inside) and a small sub-thermometer
  logic [GRP-1:0]  gt_c, eq_c, gt_m, eq_m, gt_s, eq_s;
  logic [SUBL-1:0] lo_c, lo_m, lo_s;
  logic [LINES-1:0] mux_w, therm_mid;

  always_comb begin
    for (int g = 0; g < GRP; g++) begin
      gt_c[g] = int'(code_i[CODE_W-1:SUB_W]) > g;
      eq_c[g] = int'(code_i[CODE_W-1:SUB_W]) == g;
      gt_m[g] = (MID >> SUB_W) > g;
      eq_m[g] = (MID >> SUB_W) == g;
    end
    for (int j = 0; j < SUBL; j++) begin
      lo_c[j] = int'(code_i[SUB_W-1:0]) > j;
      lo_m[j] = (MID % SUBL) > j;
    end
  end

  if (LAT == 1) begin : g_flat
    assign gt_s = gt_c;
    assign eq_s = eq_c;
    assign lo_s = lo_c;
  end else begin : g_split
    always_ff @(posedge clk) begin
      if (rst) begin
        gt_s <= gt_m;
        eq_s <= eq_m;
        lo_s <= lo_m;
      end else begin
        gt_s <= gt_c;
        eq_s <= eq_c;
        lo_s <= lo_c;
      end
    end
  end

  // per-line mux: constant one, constant zero, or the sub-thermometer line
  for (genvar i = 0; i < LINES; i++) begin : g_line
    localparam int GI = i / SUBL;
    localparam int JI = i % SUBL;
    assign mux_w[i]     = gt_s[GI] | (eq_s[GI] & lo_s[JI]);
    assign therm_mid[i] = (i < MID);
  end

  segdac_pipe #(.W(LINES), .DEPTH(TAIL)) i_tail (
    .clk     (clk),
    .rst     (rst),
    .rst_val (therm_mid),
    .d       (mux_w),
    .q       (therm_o)
  );

  // R2: a set line never sits above a cleared line
  assert_therm_shape_R2: assert property (@(posedge clk) disable iff (rst)
    ((therm_o >> 1) & ~therm_o) == '0);

endmodule

// File: rtl/segdac_cell_drv.sv
module segdac_cell_drv
  import segdac_pkg::*;
#(
  parameter bit RST_ON = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic on_i,
  output logic on_p,
  output logic on_n
);

  cell_drv_t q;

  always_ff @(posedge clk) begin
    if (rst) q <= '{drv_p: RST_ON, drv_n: !RST_ON};
    else     q <= '{drv_p: on_i,   drv_n: !on_i};
  end

  assign on_p = q.drv_p;
  assign on_n = q.drv_n;

  // R5: the two rails of a cell always disagree
  assert_rails_differ_R5: assert property (@(posedge clk) disable iff (rst)
    on_p != on_n);

endmodule

// File: rtl/segdac_frontend.sv
module segdac_frontend #(
  parameter int MSB_W   = 5,
  parameter int LSB_W   = 5,
  parameter int SUB_W   = 3,
  parameter int ENC_LAT = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [MSB_W+LSB_W-1:0]   din,
  output logic [(1<<MSB_W)-2:0]    unary_p,
  output logic [(1<<MSB_W)-2:0]    unary_n,
  output logic [LSB_W-1:0]         bin_p,
  output logic [LSB_W-1:0]         bin_n
);

  localparam int DIN_W     = MSB_W + LSB_W;
  localparam int UNARY_N   = (1 << MSB_W) - 1;
  localparam int TOTAL_LAT = ENC_LAT + 1;
  localparam int MSB_MID   = int'(segdac_pkg::field_mid(MSB_W));
  localparam int LSB_MID   = int'(segdac_pkg::field_mid(LSB_W));
  localparam int CNT_W     = $clog2(TOTAL_LAT + 1);

  logic [UNARY_N-1:0] therm_w, therm_mid;
  logic [LSB_W-1:0]   bin_dly;

  segdac_therm_enc #(.CODE_W(MSB_W), .SUB_W(SUB_W), .LAT(ENC_LAT)) i_enc (
    .clk     (clk),
    .rst     (rst),
    .code_i  (din[DIN_W-1:LSB_W]),
    .therm_o (therm_w)
  );

  segdac_pipe #(.W(LSB_W), .DEPTH(ENC_LAT)) i_bin_dly (
    .clk     (clk),
    .rst     (rst),
    .rst_val (LSB_W'(LSB_MID)),
    .d       (din[LSB_W-1:0]),
    .q       (bin_dly)
  );

  for (genvar u = 0; u < UNARY_N; u++) begin : g_ucell
    localparam bit U_RST = (u < MSB_MID);
    assign therm_mid[u] = U_RST;
    segdac_cell_drv #(.RST_ON(U_RST)) i_cell (
      .clk  (clk),
      .rst  (rst),
      .on_i (therm_w[u]),
      .on_p (unary_p[u]),
      .on_n (unary_n[u])
    );
  end

  for (genvar b = 0; b < LSB_W; b++) begin : g_bcell
    localparam bit B_RST = (b == LSB_W - 1);
    segdac_cell_drv #(.RST_ON(B_RST)) i_cell (
      .clk  (clk),
      .rst  (rst),
      .on_i (bin_dly[b]),
      .on_p (bin_p[b]),
      .on_n (bin_n[b])
    );
  end

  // steadiness window used by the latency checks below
  logic [DIN_W-1:0] din_q;
  logic [CNT_W-1:0] steady_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      din_q      <= '0;
      steady_cnt <= '0;
    end else begin
      din_q <= din;
      if (din != din_q)                         steady_cnt <= '0;
      else if (steady_cnt != CNT_W'(TOTAL_LAT)) steady_cnt <= steady_cnt + 1'b1;
    end
  end

  // R4 / R1: unary count matches the upper field once the input has been steady
  assert_code_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (steady_cnt == CNT_W'(TOTAL_LAT) && din == din_q)
      |-> ($countones(unary_p) == int'(din[DIN_W-1:LSB_W])));

  // R3: binary rails match the lower field under the same window
  assert_bin_aligned_R3: assert property (@(posedge clk) disable iff (rst)
    (steady_cnt == CNT_W'(TOTAL_LAT) && din == din_q)
      |-> (bin_p == din[LSB_W-1:0]));

  // R6: first cycle after reset shows the mid word
  assert_reset_mid_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (unary_p == therm_mid && bin_p == LSB_W'(LSB_MID)));

endmodule

// File: tb/test_segdac_frontend.sv
module test_segdac_frontend;

  localparam int CLK_PERIOD = 10;
  localparam int ENC_LAT    = 2;
  localparam int TOT        = ENC_LAT + 1;
  localparam int MID_CODE   = 528;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  din = '0;
  logic [30:0] unary_p, unary_n;
  logic [4:0]  bin_p, bin_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_q [TOT];

  always #(CLK_PERIOD/2) clk = ~clk;

  segdac_frontend #(.ENC_LAT(ENC_LAT)) i_segdac_frontend (
    .clk(clk), .rst(rst), .din(din),
    .unary_p(unary_p), .unary_n(unary_n), .bin_p(bin_p), .bin_n(bin_n)
  );

  task automatic check(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  // compare outputs against the modelled sample, then apply the next one
  task automatic step(input string tag, input logic [9:0] d, input logic r);
    logic [30:0] u_exp;
    int e;
    @(negedge clk);
    e = exp_q[TOT-1];
    for (int i = 0; i < 31; i++) u_exp[i] = (i < (e >> 5));
    check({tag, " R1 code"}, $countones(unary_p) * 32 + int'(bin_p), e);
    check({tag, " R2 thermometer"}, int'(unary_p != u_exp), 0);
    check({tag, " R3 binary"}, int'(bin_p), e % 32);
    check({tag, " R5 rails"}, int'(unary_n != ~unary_p || bin_n != ~bin_p), 0);
    for (int k = TOT - 1; k > 0; k--) exp_q[k] = exp_q[k-1];
    exp_q[0] = int'(d);
    if (r) for (int k = 0; k < TOT; k++) exp_q[k] = MID_CODE;
    din = d;
    rst = r;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < TOT; k++) exp_q[k] = MID_CODE;
    @(posedge clk);
    // R6: reset held while the input toggles
    step("R6", 10'h3FF, 1'b1);
    step("R6", 10'h000, 1'b1);
    step("R6", 10'h155, 1'b1);
    // explicit mid-word pattern check
    @(negedge clk);
    check("R6 unary mid", int'(unary_p), 32'h0000FFFF);
    check("R6 binary mid", int'(bin_p), 16);
    // R7: release, mid word held until first sample crosses the pipe
    step("R7", 10'h001, 1'b0);
    step("R7", 10'h3FE, 1'b0);
    step("R7", 10'h2AA, 1'b0);
    // R8 / R1: every code back to back
    for (int c = 0; c < 1024; c++) step("R8", 10'(c), 1'b0);
    for (int c = 1023; c >= 0; c--) step("R8", 10'(c), 1'b0);
    // R4: steps between extremes, held so both segments settle together
    for (int rpt = 0; rpt < 3; rpt++) begin
      for (int h = 0; h < TOT + 1; h++) step("R4", 10'h000, 1'b0);
      for (int h = 0; h < TOT + 1; h++) step("R4", 10'h3FF, 1'b0);
      for (int h = 0; h < TOT + 1; h++) step("R4", 10'h01F, 1'b0);
      for (int h = 0; h < TOT + 1; h++) step("R4", 10'h3E0, 1'b0);
    end
    // R6 / R7: reset in mid-stream, then recovery
    step("R6", 10'h123, 1'b1);
    step("R6", 10'h321, 1'b1);
    for (int c = 0; c < 40; c++) step("R7", 10'((c * 97 + 13) % 1024), 1'b0);
    for (int h = 0; h < TOT + 1; h++) step("R1", 10'h200, 1'b0);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule